// File: doc/BRIEF.md
# SD Command Response Checker

This block sits behind the command line of an SD host. Once a command has gone out, the command engine pulses `start_i` together with a description of the reply it expects. The description says whether a reply is expected at all and whether it is the 48-bit short form or the 136-bit long form. It also says whether the CRC should be checked, which command index was sent, and how many card-clock cycles to wait for the reply. The block then samples `cmd_in_i` once per clock and looks for the start bit. It shifts in the whole frame and runs a serial CRC-7 over the protected bits. At the end bit it reports one of three results: the reply never arrived, the CRC failed, or the frame or command index was wrong.

The controller has three states. IDLE moves to WAIT when `start_i` is accepted with a reply expected. WAIT moves to RECV when a 0 is sampled on the line, and returns to IDLE when the window runs out. RECV returns to IDLE when the end bit is sampled. An accepted `start_i` with no reply expected stays in IDLE and only produces a completion pulse. The finished frame is held in `resp_o`, with the first bit received at the most significant position of the used width.

Top module: `sd_resp_checker`

## Requirements
- R1: In IDLE, a `start_i` pulse with `resp_exp_i`=1 latches the configuration inputs and raises `busy_o` on the next cycle. A `start_i` pulse while `busy_o`=1 is ignored and does not change the latched configuration.
- R2: Let W be `tmo_cycles_i` (a value of 0 counts as 1). If the first W samples taken after the start cycle are all 1, `done_o` pulses right after the W-th sample with `err_timeout_o`=1, `err_crc_o`=0 and `err_frame_o`=0. A 0 on sample W or earlier is taken as the start bit.
- R3: A short reply is 48 bits: a start bit of 0, a transmission bit, a 6-bit index, a 32-bit argument, a 7-bit CRC and an end bit, sent most significant first. `done_o` pulses the cycle after the end bit is sampled. `resp_o[47:0]` then holds the frame with the start bit in bit 47, and `resp_o[135:48]` is 0.
- R4: With `chk_crc_i`=1, `err_crc_o` is set when the CRC-7 (polynomial x^7+x^3+1, zero initial value) over the first 40 bits of a short reply differs from the received CRC bits. With `chk_crc_i`=0, `err_crc_o` stays 0.
- R5: `err_frame_o` is set when the bit after the start bit is not 0.
- R6: For a short reply, `err_frame_o` is set when the received index (frame bits 45:40) differs from `cmd_idx_i` as latched at start.
- R7: `err_frame_o` is set when the last bit of the frame is not 1.
- R8: A long reply is 136 bits: start, transmission, six reserved bits, 120 data bits, a 7-bit CRC and an end bit. Its index field is not compared. Its CRC covers only the 120 data bits (frame bits 127:8). `resp_o` holds all 136 bits.
- R9: `done_o` is a one-cycle pulse and is never high together with `busy_o`. The error flags and `resp_o` hold until the next accepted `start_i`, which clears the flags. An accepted `start_i` with `resp_exp_i`=0 gives `done_o` on the next cycle with all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; the line is sampled on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin checking a reply |
| resp_exp_i | input | 1 | A reply is expected for this command |
| long_i | input | 1 | Reply is the 136-bit form |
| chk_crc_i | input | 1 | Compare the received CRC-7 |
| cmd_idx_i | input | 6 | Index of the command just sent |
| tmo_cycles_i | input | 16 | Cycles to wait for the start bit |
| cmd_in_i | input | 1 | Serial command line from the card |
| busy_o | output | 1 | Waiting for or receiving a reply |
| done_o | output | 1 | One-cycle completion pulse |
| err_timeout_o | output | 1 | No start bit within the window |
| err_crc_o | output | 1 | CRC-7 mismatch |
| err_frame_o | output | 1 | Transmission bit, index or end bit wrong |
| resp_o | output | 136 | Last complete reply received |

## Verification
Two events can compete on the same sample: the start bit and the end of the timeout window. The bench provokes this by delaying the start bit by exactly W-1 idle samples, which must be accepted as a start bit, and by exactly W idle samples, which must end in a timeout at that cycle. The latency of `done_o` and the flags are compared against bench-computed values. A second overlap comes from corrupting the transmission bit of a short reply, which lies inside the CRC range. This makes the framing error and the CRC error appear in the same completion, and each flag is judged on its own against the reference CRC.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } sdrc_state_e;
endpackage

// File: rtl/sdrc_crc7.sv
module sdrc_crc7 #(
    parameter int          CRC_W = 7,
    parameter logic [6:0]  POLY  = 7'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;
    assign fb = din ^ crc[CRC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end
endmodule

// File: rtl/sdrc_timer.sv
module sdrc_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
    end

    // The current sample is the (cnt_q+1)-th one in the window
    assign expire = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});
endmodule

// File: rtl/sdrc_shift.sv
module sdrc_shift #(
    parameter int LEN = 135
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic           din,
    output logic [LEN-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (en)  q <= {q[LEN-2:0], din};
    end
endmodule

// File: rtl/sd_resp_checker.sv
module sd_resp_checker
    import sdrc_pkg::*;
#(
    parameter int SHORT_LEN = 48,
    parameter int LONG_LEN  = 136,
    parameter int IDX_W     = 6,
    parameter int CRC_W     = 7,
    parameter int TMO_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                resp_exp_i,
    input  logic                long_i,
    input  logic                chk_crc_i,
    input  logic [IDX_W-1:0]    cmd_idx_i,
    input  logic [TMO_W-1:0]    tmo_cycles_i,
    input  logic                cmd_in_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_timeout_o,
    output logic                err_crc_o,
    output logic                err_frame_o,
    output logic [LONG_LEN-1:0] resp_o
);
    localparam int CNT_W     = $clog2(LONG_LEN + 1);
    localparam int SH_LEN    = LONG_LEN - 1;
    localparam int S_COV_END = SHORT_LEN - CRC_W - 1;
    localparam int L_COV_BEG = 2 + IDX_W;
    localparam int L_COV_END = LONG_LEN - CRC_W - 1;
    localparam int S_TX_POS  = SHORT_LEN - 3;
    localparam int L_TX_POS  = LONG_LEN - 3;
    localparam int S_IDX_HI  = SHORT_LEN - 4;
    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] L_LAST = CNT_W'(LONG_LEN - 1);

    sdrc_state_e        state_q, state_d;
    logic [CNT_W-1:0]   bcnt_q;
    logic               long_q, chk_q;
    logic [IDX_W-1:0]   idx_q;
    logic [TMO_W-1:0]   tmo_q;
    logic [SH_LEN-1:0]  sh_q;
    logic [CRC_W-1:0]   crc_q;
    logic               tmo_hit, crc_en, last_bit, tx_bit, frame_bad, crc_bad;
    logic               accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    sdrc_timer #(.W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_IDLE),
        .run(state_q == ST_WAIT),
        .limit(tmo_q),
        .expire(tmo_hit)
    );

    sdrc_shift #(.LEN(SH_LEN)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_WAIT),
        .en(state_q == ST_RECV),
        .din(cmd_in_i),
        .q(sh_q)
    );

    // The start bit is 0, so clearing in WAIT equals feeding it
    sdrc_crc7 #(.CRC_W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_WAIT),
        .en(crc_en),
        .din(cmd_in_i),
        .crc(crc_q)
    );

    always_comb begin
        if (long_q) crc_en = (state_q == ST_RECV) && (int'(bcnt_q) >= L_COV_BEG)
                             && (int'(bcnt_q) < L_COV_END);
        else        crc_en = (state_q == ST_RECV) && (int'(bcnt_q) < S_COV_END);
        last_bit  = (state_q == ST_RECV) && (bcnt_q == (long_q ? L_LAST : S_LAST));
        tx_bit    = long_q ? sh_q[L_TX_POS] : sh_q[S_TX_POS];
        frame_bad = tx_bit || !cmd_in_i ||
                    (!long_q && (sh_q[S_IDX_HI -: IDX_W] != idx_q));
        crc_bad   = chk_q && (crc_q != sh_q[CRC_W-1:0]);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i && resp_exp_i) state_d = ST_WAIT;
            ST_WAIT: if (!cmd_in_i)            state_d = ST_RECV;
                     else if (tmo_hit)          state_d = ST_IDLE;
            ST_RECV: if (last_bit)              state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // State register, bit counter and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            long_q  <= 1'b0;
            chk_q   <= 1'b0;
            idx_q   <= '0;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT)      bcnt_q <= CNT_W'(1);
            else if (state_q == ST_RECV) bcnt_q <= bcnt_q + 1'b1;
            if (accept) begin
                long_q <= long_i;
                chk_q  <= chk_crc_i;
                idx_q  <= cmd_idx_i;
                tmo_q  <= tmo_cycles_i;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o        <= 1'b0;
            err_timeout_o <= 1'b0;
            err_crc_o     <= 1'b0;
            err_frame_o   <= 1'b0;
            resp_o        <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    err_timeout_o <= 1'b0;
                    err_crc_o     <= 1'b0;
                    err_frame_o   <= 1'b0;
                    if (!resp_exp_i) done_o <= 1'b1;
                end
                ST_WAIT: if (cmd_in_i && tmo_hit) begin
                    done_o        <= 1'b1;
                    err_timeout_o <= 1'b1;
                end
                ST_RECV: if (last_bit) begin
                    done_o      <= 1'b1;
                    err_crc_o   <= crc_bad;
                    err_frame_o <= frame_bad;
                    resp_o      <= {sh_q, cmd_in_i};
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

module sdrc_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic resp_exp_i,
    input logic busy_o,
    input logic done_o,
    input logic err_timeout_o,
    input logic err_crc_o,
    input logic err_frame_o
);
    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && resp_exp_i) |=> busy_o);

    // R2
    timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_timeout_o) |-> (!err_crc_o && !err_frame_o));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9
    noexp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !resp_exp_i) |=> (done_o && !busy_o));

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=>
            ($stable({err_timeout_o, err_crc_o, err_frame_o}) && !done_o));
endmodule

bind sd_resp_checker sdrc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resp_exp_i(resp_exp_i),
    .busy_o(busy_o), .done_o(done_o), .err_timeout_o(err_timeout_o),
    .err_crc_o(err_crc_o), .err_frame_o(err_frame_o)
);

// File: tb/tb_sd_resp_checker.sv
module tb_sd_resp_checker;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, resp_exp_i = 1'b0, long_i = 1'b0, chk_crc_i = 1'b0;
    logic [5:0]   cmd_idx_i = '0;
    logic [15:0]  tmo_cycles_i = '0;
    logic         cmd_in_i = 1'b1;
    logic         busy_o, done_o, err_timeout_o, err_crc_o, err_frame_o;
    logic [135:0] resp_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    sd_resp_checker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .resp_exp_i(resp_exp_i),
        .long_i(long_i), .chk_crc_i(chk_crc_i), .cmd_idx_i(cmd_idx_i),
        .tmo_cycles_i(tmo_cycles_i), .cmd_in_i(cmd_in_i), .busy_o(busy_o),
        .done_o(done_o), .err_timeout_o(err_timeout_o), .err_crc_o(err_crc_o),
        .err_frame_o(err_frame_o), .resp_o(resp_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7_ref(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c;
        logic fb;
        c = '0;
        for (int i = hi; i >= lo; i--) begin
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // corrupt: 0 none, 1 transmission bit, 3 end bit, 4 CRC bit, 5 payload bit
    function automatic logic [135:0] mk_frame(input logic lng, input logic [5:0] idx,
                                              input logic [135:0] rnd, input int corrupt,
                                              input int pick);
        logic [135:0] f;
        f = '0;
        if (lng) begin
            f[133:128] = 6'h3F;
            f[127:8]   = rnd[119:0];
            f[7:1]     = crc7_ref(f, 127, 8);
            f[0]       = 1'b1;
            if (corrupt == 1) f[134] = 1'b1;
            if (corrupt == 5) f[8 + pick % 120] ^= 1'b1;
        end else begin
            f[45:40] = idx;
            f[39:8]  = rnd[31:0];
            f[7:1]   = crc7_ref(f, 47, 8);
            f[0]     = 1'b1;
            if (corrupt == 1) f[46] = 1'b1;
            if (corrupt == 5) f[8 + pick % 32] ^= 1'b1;
        end
        if (corrupt == 3) f[0] = 1'b0;
        if (corrupt == 4) f[1 + pick % 7] ^= 1'b1;
        return f;
    endfunction

    task automatic run_txn(input logic lng, input logic chk, input logic [5:0] sent_idx,
                           input int tmo, input int delay, input logic [135:0] fr,
                           input bit poke, input string tag);
        int n, win, exp_cyc, cyc, seen_cyc;
        bit exp_to, exp_crc, exp_frm, seen;
        logic [135:0] exp_resp;
        n      = lng ? 136 : 48;
        win    = (tmo < 1) ? 1 : tmo;
        exp_to = (delay >= win);
        exp_cyc = exp_to ? win : delay + n;
        exp_crc = 1'b0;
        exp_frm = 1'b0;
        exp_resp = resp_o;
        if (!exp_to) begin
            exp_resp = fr;
            if (lng) exp_crc = chk && (crc7_ref(fr, 127, 8) != fr[7:1]);
            else     exp_crc = chk && (crc7_ref(fr, 47, 8) != fr[7:1]);
            exp_frm = fr[n-2] || !fr[0] || (!lng && (fr[45:40] != sent_idx));
        end
        @(negedge clk);
        start_i = 1'b1; resp_exp_i = 1'b1; long_i = lng; chk_crc_i = chk;
        cmd_idx_i = sent_idx; tmo_cycles_i = 16'(tmo); cmd_in_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R1", {tag, " busy after start"}, 136'(busy_o), 136'(1));
        seen = 1'b0; seen_cyc = -1; cyc = 0;
        while (!seen && cyc < 400) begin
            if (cyc < delay)          cmd_in_i = 1'b1;
            else if (cyc - delay < n) cmd_in_i = fr[n-1-(cyc-delay)];
            else                      cmd_in_i = 1'b1;
            if (poke && cyc == 1) begin
                start_i = 1'b1; resp_exp_i = 1'b1; long_i = ~lng;
                cmd_idx_i = ~sent_idx; tmo_cycles_i = 16'(1);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (done_o === 1'b1) begin seen = 1'b1; seen_cyc = cyc; end
        end
        start_i = 1'b0; cmd_in_i = 1'b1;
        check(seen_cyc == exp_cyc, exp_to ? "R2" : "R3", {tag, " done cycle"},
              136'(seen_cyc), 136'(exp_cyc));
        check(busy_o === 1'b0, "R9", {tag, " idle at done"}, 136'(busy_o), 136'(0));
        check(err_timeout_o === exp_to, "R2", {tag, " timeout flag"},
              136'(err_timeout_o), 136'(exp_to));
        check(err_crc_o === exp_crc, lng ? "R8" : "R4", {tag, " crc flag"},
              136'(err_crc_o), 136'(exp_crc));
        check(err_frame_o === exp_frm, "R5 R6 R7", {tag, " frame flag"},
              136'(err_frame_o), 136'(exp_frm));
        check(resp_o === exp_resp, lng ? "R8" : "R3", {tag, " response"}, resp_o, exp_resp);
    endtask

    initial begin
        #(CLK_P * 190000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [135:0] rnd, fr;
        logic [5:0]   idx;
        void'($urandom(32'h5D17));
        repeat (3) @(negedge clk);
        check({busy_o, done_o, err_timeout_o, err_crc_o, err_frame_o} === 5'b0, "R9",
              "reset outputs", 136'({busy_o, done_o, err_timeout_o, err_crc_o, err_frame_o}), 136'(0));
        check(resp_o === '0, "R3", "reset response", resp_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: no reply expected
        start_i = 1'b1; resp_exp_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b1 && busy_o === 1'b0, "R9", "no-reply done",
              136'({done_o, busy_o}), 136'(2));
        check({err_timeout_o, err_crc_o, err_frame_o} === 3'b0, "R9", "no-reply flags",
              136'({err_timeout_o, err_crc_o, err_frame_o}), 136'(0));

        rnd = {$urandom, $urandom, $urandom, $urandom, $urandom};
        // R3 R4 clean short reply
        fr = mk_frame(1'b0, 6'd17, rnd, 0, 0);
        run_txn(1'b0, 1'b1, 6'd17, 10, 3, fr, 1'b0, "short ok");
        // R2 window boundary: start bit on the last allowed sample, then one late
        run_txn(1'b0, 1'b1, 6'd17, 5, 4, fr, 1'b0, "edge accept");
        run_txn(1'b0, 1'b1, 6'd17, 5, 5, fr, 1'b0, "edge timeout");
        run_txn(1'b0, 1'b1, 6'd17, 0, 2, fr, 1'b0, "zero window");
        // R5 with R4 overlap: transmission bit is CRC-covered
        run_txn(1'b0, 1'b1, 6'd9, 8, 1, mk_frame(1'b0, 6'd9, rnd, 1, 0), 1'b0, "tx bit");
        // R6 index mismatch
        run_txn(1'b0, 1'b1, 6'd10, 8, 0, mk_frame(1'b0, 6'd11, rnd, 0, 0), 1'b0, "index");
        // R7 end bit
        run_txn(1'b0, 1'b1, 6'd3, 8, 2, mk_frame(1'b0, 6'd3, rnd, 3, 0), 1'b0, "end bit");
        // R4 CRC flip, checked and unchecked
        fr = mk_frame(1'b0, 6'd44, rnd, 4, 3);
        run_txn(1'b0, 1'b1, 6'd44, 8, 2, fr, 1'b0, "crc on");
        run_txn(1'b0, 1'b0, 6'd44, 8, 2, fr, 1'b0, "crc off");
        // R9 flags hold while idle
        repeat (6) @(negedge clk);
        check(done_o === 1'b0 && err_crc_o === 1'b0 && err_frame_o === 1'b0, "R9",
              "hold after done", 136'({done_o, err_crc_o, err_frame_o}), 136'(0));
        check(resp_o === fr, "R9", "response held", resp_o, fr);
        // R8 long reply: good, index ignored, CRC error
        fr = mk_frame(1'b1, 6'd0, rnd, 0, 0);
        run_txn(1'b1, 1'b1, 6'd2, 12, 4, fr, 1'b0, "long ok");
        run_txn(1'b1, 1'b1, 6'd2, 12, 1, mk_frame(1'b1, 6'd0, rnd, 5, 77), 1'b0, "long crc");
        // R1 start while busy ignored
        run_txn(1'b0, 1'b1, 6'd21, 9, 3, mk_frame(1'b0, 6'd21, rnd, 0, 0), 1'b1, "busy start");

        for (int t = 0; t < 80; t++) begin
            logic lng, chk;
            int corrupt, tmo, delay;
            lng     = ($urandom % 3) == 0;
            chk     = ($urandom % 4) != 0;
            corrupt = $urandom % 6;
            tmo     = 1 + ($urandom % 12);
            delay   = $urandom % (tmo + 2);
            idx     = 6'($urandom);
            rnd     = {$urandom, $urandom, $urandom, $urandom, $urandom};
            fr      = mk_frame(lng, idx, rnd, corrupt, int'($urandom % 1000));
            run_txn(lng, chk, (corrupt == 2) ? (idx ^ 6'h01) : idx, tmo, delay, fr,
                    1'b0, "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule